// File: doc/BRIEF.md
# Coherency Unit Control and Status Registers

This block is the register front end of a multicore cluster's coherency unit. It answers a simple memory-mapped bus with a 256-byte window. The host drives an offset, write data, a write enable, an access size in bytes and a read enable. Read data comes back one clock later.

The window holds three live registers. A one-bit enable register is cleared by reset. A read-only configuration word is built from the CPU-count parameter. A 32-bit per-CPU power status word can be written one byte at a time, or in half-words or words that start at any of its four byte offsets. Several slots read as zero and ignore writes: the invalidate-all slot, the two filter address slots and the two access-control slots. Every offset that is not decoded behaves the same way.

Each access is sorted by a combinational decoder into one of five classes: none, control, configuration, power and read-as-zero. A `unique case` on that class selects both the read value and the register that a write updates. The block has no sequencing states. Every access completes in the cycle it is presented.

Top module: `snoop_ctl_regs`

## Requirements
- R1: An offset that is not decoded (anything other than 0x00, 0x04, 0x08 to 0x0B, 0x0C, 0x40, 0x44, 0x50 or 0x54) reads 0x00000000, and a write to it changes neither the control nor the power status register.
- R2: A valid write to offset 0x00 stores bit 0 of `wdata` in the control register and discards bits 31:1. Reading offset 0x00 returns that bit in bit 0 with bits 31:1 zero. Reset sets the control bit to 0.
- R3: Offset 0x04 reads ((2^N - 1) << 4) | (N - 1), where N is `NUM_CPU` (1 to 4, default 1, giving 0x00000010). Writes to 0x04 have no effect.
- R4: A read at offset 0x08+k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with the upper bits zero-filled.
- R5: A write at offset 0x08+k uses a mask set by `size`: 0xFF for 1, 0xFFFF for 2, 0xFFFFFFFF for 4. The mask is shifted left by 8*k. The bits under the shifted mask are replaced by (`wdata` & mask) << 8*k. All other bits are kept. Bits shifted past bit 31 are dropped.
- R6: A write whose `size` is not 1, 2 or 4 changes no register at any offset.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54 read 0x00000000. A write to any of them changes neither the control nor the power status register.
- R8: Reset clears the control register only. The power status word keeps its value through reset.
- R9: `rdata` takes the selected value at the clock edge where `rd_en` is high. It holds that value while `rd_en` is low. Reset sets it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset within the window |
| wr_en | input | 1 | Write enable, acts on the rising edge |
| wdata | input | 32 | Write data, right-aligned |
| size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| rd_en | input | 1 | Read enable |
| rdata | output | 32 | Registered read data |

## Verification
The power word is exercised with every size at every byte offset, and each result is compared with a lane-mask model. After each write, all four byte offsets are read back. This separates a wrong mask width from a wrong shift, and it shows the four-byte write at 0x0B losing its upper bytes. Writes of all ones are sent to the read-as-zero slots, to undecoded offsets and with illegal sizes. Reading back the control and power registers afterwards shows whether a write leaked into live state. A reset taken with known values in both registers shows that only the control bit clears, and a read of 0x04 shows the configuration value is derived correctly from the parameter.

// File: rtl/snoop_regs_pkg.sv
package snoop_regs_pkg;

    localparam int WIN_BYTES = 256;
    localparam int ADDR_W    = $clog2(WIN_BYTES);
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PWR    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_INVAL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLT_LO = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FLT_HI = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_ACC_S  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_ACC_NS = 8'h54;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CTRL,
        KIND_CFG,
        KIND_PWR,
        KIND_RAZ
    } reg_kind_t;

    // Lane mask for an access size given in bytes. Zero marks an illegal size.
    function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    size_mask = 32'h0000_00FF;
            3'd2:    size_mask = 32'h0000_FFFF;
            3'd4:    size_mask = 32'hFFFF_FFFF;
            default: size_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/snoop_addr_decode.sv
module snoop_addr_decode
    import snoop_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_t         kind,
    output logic [1:0]        lane
);

    always_comb begin
        lane = addr[1:0];
        if (addr[ADDR_W-1:2] == OFS_PWR[ADDR_W-1:2]) begin
            kind = KIND_PWR;
        end else begin
            unique case (addr)
                OFS_CTRL:   kind = KIND_CTRL;
                OFS_CFG:    kind = KIND_CFG;
                OFS_INVAL,
                OFS_FLT_LO,
                OFS_FLT_HI,
                OFS_ACC_S,
                OFS_ACC_NS: kind = KIND_RAZ;
                default:    kind = KIND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/snoop_pwr_status.sv
module snoop_pwr_status
    import snoop_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status
);

    logic [4:0]        shamt;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;

    always_comb begin
        shamt     = {lane, 3'b000};
        lane_mask = mask << shamt;
        lane_data = (wdata & mask) << shamt;
    end

    // No reset: the power word survives reset by design.
    always_ff @(posedge clk) begin
        if (wr_hit) begin
            status <= (status & ~lane_mask) | lane_data;
        end
    end

    // R5: bits outside the shifted lane mask are untouched by a write
    assert_lane_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((status & ~$past(lane_mask)) == ($past(status) & ~$past(lane_mask))));

    // R5: bits under the shifted lane mask take the shifted write data
    assert_lane_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((status & $past(lane_mask)) == $past(lane_data)));

    // R6: without a write hit the word holds
    assert_pwr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(status));

endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
    import snoop_regs_pkg::*;
#(
    parameter int NUM_CPU = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic [2:0]        size,
    input  logic              rd_en,
    output logic [31:0]       rdata
);

    localparam logic [DATA_W-1:0] CPU_MASK = (32'd1 << NUM_CPU) - 32'd1;
    localparam logic [DATA_W-1:0] CFG_WORD = (CPU_MASK << 4) | 32'(NUM_CPU - 1);

    reg_kind_t         kind;
    logic [1:0]        lane;
    logic [DATA_W-1:0] mask;
    logic              size_ok;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_word;
    logic [DATA_W-1:0] rd_val;

    snoop_addr_decode u_decode (
        .addr (addr),
        .kind (kind),
        .lane (lane)
    );

    always_comb begin
        mask    = size_mask(size);
        size_ok = (mask != '0);
    end

    snoop_pwr_status u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_en && size_ok && (kind == KIND_PWR)),
        .lane   (lane),
        .mask   (mask),
        .wdata  (wdata),
        .status (pwr_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (wr_en && size_ok && (kind == KIND_CTRL)) begin
            ctrl_q <= wdata[0];
        end
    end

    always_comb begin
        unique case (kind)
            KIND_CTRL: rd_val = {31'd0, ctrl_q};
            KIND_CFG:  rd_val = CFG_WORD;
            KIND_PWR:  rd_val = pwr_word >> {lane, 3'b000};
            KIND_RAZ,
            KIND_NONE: rd_val = '0;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    // R2: a valid control write lands only bit 0
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size_ok && addr == OFS_CTRL) |=> (ctrl_q == $past(wdata[0])));

    // R2: control readback has bits 31:1 clear
    assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(addr) == OFS_CTRL) |-> (rdata[31:1] == '0));

    // R3: configuration word follows the CPU count
    assert_cfg_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(addr) == OFS_CFG) |-> (rdata == CFG_WORD));

    // R7 and R1: read-as-zero slots and undecoded offsets
    assert_raz_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && ($past(kind) == KIND_RAZ || $past(kind) == KIND_NONE))
            |-> (rdata == '0));

    // R6: an illegal size leaves the control bit alone
    assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_ok) |=> $stable(ctrl_q));

    // R9: read data holds without a read
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rdata));

endmodule

// File: tb/test_snoop_ctl_regs.sv
module test_snoop_ctl_regs;

    localparam int NCPU = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [2:0]  size = 3'd4;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_pwr;
    logic        m_ctrl;

    always #4 clk = ~clk;

    snoop_ctl_regs #(.NUM_CPU(NCPU)) i_snoop_ctl_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .size  (size),
        .rd_en (rd_en),
        .rdata (rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
        @(negedge clk);
        addr = a; wdata = d; size = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] model_wr(input logic [31:0] cur, input int k,
                                             input logic [31:0] d, input int s);
        logic [31:0] m;
        m = (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        return (cur & ~(m << (8 * k))) | ((d & m) << (8 * k));
    endfunction

    task automatic check_state(input string req);
        logic [31:0] v;
        rd(8'h00, v); check(req, v, {31'd0, m_ctrl});
        for (int k = 0; k < 4; k++) begin
            rd(8'h08 + 8'(k), v); check(req, v, m_pwr >> (8 * k));
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R9 rdata after reset", rdata, 32'd0);
        rd(8'h00, v); check("R2 control reset", v, 32'd0);
    endtask

    task automatic t_config;
        logic [31:0] v;
        logic [31:0] exp;
        exp = (((32'd1 << NCPU) - 1) << 4) | 32'(NCPU - 1);
        rd(8'h04, v); check("R3 config word", v, exp);
        wr(8'h04, 32'h0, 3'd4);
        rd(8'h04, v); check("R3 config after write", v, exp);
    endtask

    task automatic t_control;
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF, 3'd4); m_ctrl = 1'b1;
        rd(8'h00, v); check("R2 control set", v, 32'd1);
        wr(8'h00, 32'h0000_0002, 3'd1); m_ctrl = 1'b0;
        rd(8'h00, v); check("R2 control bit0 only", v, 32'd0);
        wr(8'h00, 32'h0000_0001, 3'd2); m_ctrl = 1'b1;
        rd(8'h00, v); check("R2 control half write", v, 32'd1);
    endtask

    task automatic t_power;
        wr(8'h08, 32'h1234_5678, 3'd4); m_pwr = 32'h1234_5678;
        check_state("R4 power byte reads");
        for (int k = 0; k < 4; k++) begin
            for (int si = 0; si < 3; si++) begin
                int s;
                logic [31:0] d;
                s = (si == 0) ? 1 : (si == 1) ? 2 : 4;
                d = 32'hA1B2C3D4 ^ (32'(k) << 8) ^ 32'(si * 37);
                wr(8'h08 + 8'(k), d, 3'(s));
                m_pwr = model_wr(m_pwr, k, d, s);
                check_state("R5 lane write");
            end
        end
        wr(8'h08, 32'h0, 3'd4); m_pwr = 32'h0;
        wr(8'h0B, 32'hCAFE_F00D, 3'd4); m_pwr = 32'h0D00_0000;
        check_state("R5 truncated word at 0x0B");
    endtask

    task automatic t_bad_size;
        for (int s = 0; s < 8; s++) begin
            if (s != 1 && s != 2 && s != 4) begin
                wr(8'h08, 32'hFFFF_FFFF, 3'(s));
                wr(8'h0A, 32'hFFFF_FFFF, 3'(s));
                wr(8'h00, {31'd0, ~m_ctrl}, 3'(s));
            end
        end
        check_state("R6 illegal size ignored");
    endtask

    task automatic t_raz;
        logic [31:0] v;
        logic [7:0] raz [5] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54};
        foreach (raz[i]) begin
            wr(raz[i], 32'hFFFF_FFFF, 3'd4);
            rd(raz[i], v); check("R7 read as zero", v, 32'd0);
        end
        check_state("R7 writes ignored");
    endtask

    task automatic t_undecoded;
        logic [31:0] v;
        logic [7:0] ofs [5] = '{8'h05, 8'h10, 8'h48, 8'h80, 8'hFF};
        foreach (ofs[i]) begin
            wr(ofs[i], 32'hFFFF_FFFF, 3'd4);
            rd(ofs[i], v); check("R1 undecoded reads zero", v, 32'd0);
        end
        check_state("R1 undecoded writes ignored");
    endtask

    task automatic t_hold;
        logic [31:0] v;
        rd(8'h04, v);
        @(negedge clk); addr = 8'h00;
        repeat (3) @(negedge clk);
        check("R9 rdata holds without read", rdata, v);
    endtask

    task automatic t_reset_keep;
        wr(8'h00, 32'h1, 3'd4); m_ctrl = 1'b1;
        wr(8'h08, 32'h5A5A_C3C3, 3'd4); m_pwr = 32'h5A5A_C3C3;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_ctrl = 1'b0;
        check_state("R8 reset keeps power clears control");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 1'b0;
        m_pwr = '0;
        t_reset();
        t_config();
        t_control();
        t_power();
        t_bad_size();
        t_raz();
        t_undecoded();
        t_hold();
        t_reset_keep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule